// File: doc/BRIEF.md
# Watchdog Timer with Keyed Restart

A memory-mapped down-counter guards against stalled software. Software loads a reload value, then writes a fixed 16-bit key to the restart register, which copies the reload value into the live counter. While enabled, the counter decrements once per step. A step is every clock cycle, or, when the time-base bit is set, each cycle in which the 1 MHz tick enable is high. When the counter is already zero at a step, the block flags a sticky timeout, can emit a one-cycle reset request and a one-cycle external-signal request, and reloads itself to keep running.

An early-warning threshold sits in the upper control bits. When a step finds the counter equal to that threshold and the interrupt enable is set, a sticky interrupt flag is raised, and it drives the interrupt output. Both sticky flags clear only through a dedicated clear register. The reset scope code goes straight from the control register to an output. Clock generation, reset distribution and pulse shaping are handled by other blocks.

If counting is enabled while the counter is still zero, the block times out at the first step. Software should therefore load the reload value and write the key before it enables counting.

Top module: `wdog_core`

## Requirements
- R1: After reset the counter, control and status registers read zero, the reload register reads 0xFFFFFFFF, and rst_req, ext_req and irq are low.
- R2: Offset 0x04 holds the reload value, and it can be read and written. Writing exactly 0x00004755 to offset 0x08 copies the reload value into the counter at that edge. Any other value written there, including one with that low half and nonzero upper bits, leaves the counter unchanged. Offset 0x08 reads zero.
- R3: Offset 0x0C is the control word. Bits 31:10 and 6:0 are stored, and bits 9:7 read zero. Bit 0 enables counting. While bit 0 is clear, the counter holds its value.
- R4: Control bit 4 set means a step happens only in cycles where tick_1us is high. With bit 4 clear, every clock cycle is a step.
- R5: At a step where the counter is zero, the counter takes the reload value and status bit 0 becomes 1. In the following cycle rst_req is high for one cycle if control bit 1 was set, and ext_req is high for one cycle if control bit 3 was set. At any other step the counter decrements by one.
- R6: At a step where the counter equals the control word with bits 9:0 forced to zero, and control bit 2 is set, status bit 2 becomes 1. irq follows status bit 2.
- R7: rst_scope always equals control bits 6:5. The codes are 00 SoC, 01 full chip and 10 CPU only.
- R8: Offset 0x10 reads status. Bit 0 is the timeout flag, bit 2 is the early-warning flag, and all other bits are zero. Writes to 0x10 are ignored. Writing offset 0x14 with bit 0 set clears both flags. Writing it with bit 0 clear does nothing. Offset 0x14 reads zero. A flag event in the same cycle as a clear leaves the flag set.
- R9: A key write to the restart register in the same cycle as a step takes priority. The counter loads the reload value, and neither an expiry nor an early warning happens at that edge.
- R10: Offset 0x00 reads the live counter, and writes to it are ignored. Any other address, including unaligned ones, reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | 1 MHz tick enable, high for one cycle per microsecond |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_scope | output | 2 | Reset scope code |
| ext_req | output | 1 | One-cycle external-signal request on expiry |
| irq | output | 1 | Early-warning interrupt |

## Verification
A keyed restart and a counter expiry can fall on the same clock edge. The bench provokes this by idling until its own model holds a zero count, then issuing the key write in the next cycle. It then judges that the counter holds the reload value, that rst_req stays low and that the timeout flag does not change. A clear write is aimed at an expiry edge in the same way, and the timeout flag must survive it. Random traffic with small reload values and thresholds makes both collisions recur many times.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned OFS_COUNT  = 'h00;
   localparam int unsigned OFS_RELOAD = 'h04;
   localparam int unsigned OFS_KICK   = 'h08;
   localparam int unsigned OFS_CTRL   = 'h0C;
   localparam int unsigned OFS_STAT   = 'h10;
   localparam int unsigned OFS_CLEAR  = 'h14;

   localparam int unsigned CB_RUN  = 0;
   localparam int unsigned CB_RST  = 1;
   localparam int unsigned CB_WARN = 2;
   localparam int unsigned CB_EXT  = 3;
   localparam int unsigned CB_USEC = 4;
   localparam int unsigned CB_SCOPE_LO = 5;

   typedef enum logic [1:0] {
      SCOPE_SOC  = 2'b00,
      SCOPE_CHIP = 2'b01,
      SCOPE_CPU  = 2'b10
   } wd_scope_e;

   typedef struct packed {
      logic kick;
      logic wr_reload;
      logic wr_ctrl;
      logic clear;
   } wd_wr_t;
endpackage

// File: rtl/wdog_decode.sv
module wdog_decode
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter logic [15:0] KEY    = 16'h4755
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output wd_wr_t            wr
);
   localparam logic [DATA_W-1:0] KEY_FULL = DATA_W'(KEY);

   always_comb begin
      wr.kick      = bus_we && (bus_addr == ADDR_W'(OFS_KICK)) && (bus_wdata == KEY_FULL);
      wr.wr_reload = bus_we && (bus_addr == ADDR_W'(OFS_RELOAD));
      wr.wr_ctrl   = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
      wr.clear     = bus_we && (bus_addr == ADDR_W'(OFS_CLEAR)) && bus_wdata[0];
   end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int unsigned CNT_W         = 32,
   parameter bit          HAS_FAST_BASE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             usec_sel,
   input  logic             tick,
   input  logic             kick,
   input  logic             warn_en,
   input  logic [CNT_W-1:0] reload,
   input  logic [CNT_W-1:0] thr,
   output logic [CNT_W-1:0] cnt,
   output logic             expire,
   output logic             prewarn
);
   logic step;

   generate
      if (HAS_FAST_BASE) begin : g_sel_base
         assign step = run & (usec_sel ? tick : 1'b1);
      end else begin : g_tick_only
         logic sel_unused;
         assign sel_unused = usec_sel;
         assign step = run & tick;
      end
   endgenerate

   assign expire  = step & ~kick & (cnt == '0);
   assign prewarn = step & ~kick & warn_en & (cnt == thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (kick) begin
         cnt <= reload;
      end else if (step) begin
         cnt <= (cnt == '0) ? reload : cnt - 1'b1;
      end
   end
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic prewarn,
   input  logic clear,
   input  logic rst_en,
   input  logic ext_en,
   output logic exp_sts,
   output logic pre_sts,
   output logic rst_req,
   output logic ext_req
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_sts <= 1'b0;
         pre_sts <= 1'b0;
         rst_req <= 1'b0;
         ext_req <= 1'b0;
      end else begin
         exp_sts <= expire  | (exp_sts & ~clear);
         pre_sts <= prewarn | (pre_sts & ~clear);
         rst_req <= expire & rst_en;
         ext_req <= expire & ext_en;
      end
   end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W        = 5,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned THR_LSB       = 10,
   parameter logic [15:0] KEY           = 16'h4755,
   parameter bit          HAS_FAST_BASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1us,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req,
   output logic [1:0]        rst_scope,
   output logic              ext_req,
   output logic              irq
);
   localparam logic [DATA_W-1:0] THR_MASK  = {DATA_W{1'b1}} << THR_LSB;
   localparam logic [DATA_W-1:0] CTRL_MASK = THR_MASK | DATA_W'(7'h7F);
   localparam logic [DATA_W-1:0] RELOAD_RST = {DATA_W{1'b1}};

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("wdog_core: ADDR_W must reach offset 0x14");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("wdog_core: DATA_W must hold the restart key");
      end
      if (THR_LSB < 7 || THR_LSB >= DATA_W) begin : g_bad_thr
         $error("wdog_core: THR_LSB must sit above the control bits");
      end
   endgenerate

   wd_wr_t            wr;
   logic              kick_hit;
   logic              clr_hit;
   logic [DATA_W-1:0] ctl_q;
   logic [DATA_W-1:0] reload_q;
   logic [DATA_W-1:0] cnt_q;
   logic              expire;
   logic              prewarn;
   logic              exp_sts;
   logic              pre_sts;

   wdog_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY(KEY)) u_decode (
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_we   (bus_we),
      .wr       (wr)
   );

   assign kick_hit = wr.kick;
   assign clr_hit  = wr.clear;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q    <= '0;
         reload_q <= RELOAD_RST;
      end else begin
         if (wr.wr_ctrl)   ctl_q    <= bus_wdata & CTRL_MASK;
         if (wr.wr_reload) reload_q <= bus_wdata;
      end
   end

   wdog_count #(.CNT_W(DATA_W), .HAS_FAST_BASE(HAS_FAST_BASE)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctl_q[CB_RUN]),
      .usec_sel(ctl_q[CB_USEC]),
      .tick    (tick_1us),
      .kick    (kick_hit),
      .warn_en (ctl_q[CB_WARN]),
      .reload  (reload_q),
      .thr     (ctl_q & THR_MASK),
      .cnt     (cnt_q),
      .expire  (expire),
      .prewarn (prewarn)
   );

   wdog_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .prewarn(prewarn),
      .clear  (clr_hit),
      .rst_en (ctl_q[CB_RST]),
      .ext_en (ctl_q[CB_EXT]),
      .exp_sts(exp_sts),
      .pre_sts(pre_sts),
      .rst_req(rst_req),
      .ext_req(ext_req)
   );

   assign irq       = pre_sts;
   assign rst_scope = ctl_q[CB_SCOPE_LO +: 2];

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_COUNT):  bus_rdata = cnt_q;
         ADDR_W'(OFS_RELOAD): bus_rdata = reload_q;
         ADDR_W'(OFS_CTRL):   bus_rdata = ctl_q;
         ADDR_W'(OFS_STAT):   bus_rdata = DATA_W'({pre_sts, 1'b0, exp_sts});
         default:             bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              kick_hit,
   input logic              clr_hit,
   input logic [DATA_W-1:0] cnt_q,
   input logic [DATA_W-1:0] reload_q,
   input logic [DATA_W-1:0] ctl_q,
   input logic              exp_sts,
   input logic              rst_req,
   input logic              ext_req,
   input logic              irq
);
   p_kick_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      kick_hit |=> (cnt_q == $past(reload_q)));

   p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q[CB_RUN] && !kick_hit) |=> $stable(cnt_q));

   p_rst_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> exp_sts);

   p_ext_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ext_req |-> exp_sts);

   p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ctl_q[CB_WARN]));

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_sts && !clr_hit) |=> exp_sts);

   p_clear_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(OFS_CLEAR)) |-> (bus_rdata == '0));
endmodule

bind wdog_core wdog_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr),
   .bus_rdata(bus_rdata),
   .kick_hit (kick_hit),
   .clr_hit  (clr_hit),
   .cnt_q    (cnt_q),
   .reload_q (reload_q),
   .ctl_q    (ctl_q),
   .exp_sts  (exp_sts),
   .rst_req  (rst_req),
   .ext_req  (ext_req),
   .irq      (irq)
);

// File: tb/wdog_core_bench.sv
`timescale 1ns/1ps
module wdog_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_tick = 1'b0;
   logic [4:0]  b_addr = '0;
   logic [31:0] b_wd = '0;
   logic        b_we = 1'b0;
   logic [31:0] rdata;
   logic        rst_req, ext_req, irq;
   logic [1:0]  scope;

   int unsigned n_chk = 0;
   int unsigned n_fail = 0;
   bit          done = 1'b0;
   string       phase = "R1";

   // reference state
   logic [31:0] m_cnt, m_rel, m_ctl;
   logic        m_s0, m_s2, m_rst, m_ext;

   always #2 clk = ~clk;

   wdog_core u_wdog_core (
      .clk(clk), .rst_n(rst_n), .tick_1us(b_tick),
      .bus_addr(b_addr), .bus_wdata(b_wd), .bus_we(b_we),
      .bus_rdata(rdata), .rst_req(rst_req), .rst_scope(scope),
      .ext_req(ext_req), .irq(irq)
   );

   always @(posedge clk) begin
      logic key, clr, step, f_exp, f_pre;
      if (!rst_n) begin
         m_cnt = '0; m_rel = 32'hFFFF_FFFF; m_ctl = '0;
         m_s0 = 0; m_s2 = 0; m_rst = 0; m_ext = 0;
      end else begin
         key   = b_we && b_addr == 5'h08 && b_wd == 32'h0000_4755;
         clr   = b_we && b_addr == 5'h14 && b_wd[0];
         step  = m_ctl[0] && (m_ctl[4] ? b_tick : 1'b1);
         f_exp = 0; f_pre = 0;
         if (key) m_cnt = m_rel;
         else if (step) begin
            if (m_ctl[2] && m_cnt == {m_ctl[31:10], 10'b0}) f_pre = 1;
            if (m_cnt == 0) begin f_exp = 1; m_cnt = m_rel; end
            else m_cnt = m_cnt - 1;
         end
         if (clr) begin m_s0 = 0; m_s2 = 0; end
         if (f_exp) m_s0 = 1;
         if (f_pre) m_s2 = 1;
         m_rst = f_exp && m_ctl[1];
         m_ext = f_exp && m_ctl[3];
         if (b_we && b_addr == 5'h04) m_rel = b_wd;
         if (b_we && b_addr == 5'h0C) m_ctl = b_wd & 32'hFFFF_FC7F;
      end
   end

   function automatic logic [31:0] model_rd(input logic [4:0] a);
      case (a)
         5'h00: return m_cnt;
         5'h04: return m_rel;
         5'h0C: return m_ctl;
         5'h10: return {29'b0, m_s2, 1'b0, m_s0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [4:0] a);
      case (a)
         5'h00: return "R10 counter read";
         5'h04: return "R2 reload read";
         5'h08: return "R2 restart reads zero";
         5'h0C: return "R3 control read";
         5'h10: return "R8 status read";
         5'h14: return "R8 clear reads zero";
         default: return "R10 unmapped read";
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL [%s] %s actual=%h expected=%h at %0t", phase, req, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic we, input logic [4:0] a, input logic [31:0] d, input logic t);
      @(negedge clk);
      b_we = we; b_addr = a; b_wd = d; b_tick = t;
      #1;
      chk(tag_of(a), rdata, model_rd(a));
      @(posedge clk);
      #1;
      chk("R5 rst_req", {31'b0, rst_req}, {31'b0, m_rst});
      chk("R5 ext_req", {31'b0, ext_req}, {31'b0, m_ext});
      chk("R6 irq", {31'b0, irq}, {31'b0, m_s2});
      chk("R7 rst_scope", {30'b0, scope}, {30'b0, m_ctl[6:5]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired, run hung");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0_FFEE));
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      phase = "R1";
      chk("R1 rst_req low", {31'b0, rst_req}, 32'h0);
      chk("R1 irq low", {31'b0, irq}, 32'h0);
      foreach (model_rd_addrs[i]) cyc(0, model_rd_addrs[i], 0, 0);

      phase = "R2";
      cyc(1, 5'h04, 32'd100, 0);
      cyc(1, 5'h08, 32'h0000_4754, 0);
      cyc(0, 5'h00, 0, 0);
      cyc(1, 5'h08, 32'h0001_4755, 0);
      cyc(0, 5'h00, 0, 0);
      cyc(1, 5'h08, 32'h0000_4755, 0);
      cyc(0, 5'h00, 0, 0);

      phase = "R3";
      cyc(1, 5'h00, 32'h55, 0);
      cyc(1, 5'h0C, 32'hFFFF_FFFF, 0);
      cyc(0, 5'h0C, 0, 0);
      cyc(0, 5'h00, 0, 0);
      cyc(1, 5'h0C, 32'h0, 0);

      phase = "R4";
      cyc(1, 5'h0C, 32'h11, 0);
      for (int i = 0; i < 24; i++) cyc(0, 5'h00, 0, 1'($urandom % 2));
      cyc(1, 5'h0C, 32'h10, 1);
      for (int i = 0; i < 5; i++) cyc(0, 5'h00, 0, 1);

      phase = "R5";
      cyc(1, 5'h04, 32'd6, 0);
      cyc(1, 5'h08, 32'h4755, 0);
      cyc(1, 5'h0C, 32'h4B, 0);
      for (int i = 0; i < 20; i++) cyc(0, (i % 2) ? 5'h10 : 5'h00, 0, 0);
      cyc(1, 5'h14, 32'h1, 0);

      phase = "R9";
      while (m_cnt != 0) cyc(0, 5'h00, 0, 0);
      cyc(1, 5'h08, 32'h4755, 0);
      cyc(0, 5'h10, 0, 0);
      cyc(0, 5'h00, 0, 0);

      phase = "R8";
      while (m_cnt != 0) cyc(0, 5'h00, 0, 0);
      cyc(1, 5'h14, 32'h1, 0);
      cyc(0, 5'h10, 0, 0);
      cyc(1, 5'h14, 32'h2, 0);
      cyc(1, 5'h10, 32'h0, 0);
      cyc(0, 5'h10, 0, 0);
      cyc(1, 5'h14, 32'h1, 0);
      cyc(0, 5'h10, 0, 0);

      phase = "R6";
      cyc(1, 5'h0C, 32'h0, 0);
      cyc(1, 5'h04, 32'd1030, 0);
      cyc(1, 5'h08, 32'h4755, 0);
      cyc(1, 5'h0C, 32'h407, 0);
      for (int i = 0; i < 1040; i++) cyc(0, 5'h10, 0, 0);

      phase = "R7";
      cyc(1, 5'h0C, 32'h20, 0);
      cyc(1, 5'h0C, 32'h40, 0);
      cyc(1, 5'h0C, 32'h0, 0);

      phase = "RND";
      for (int i = 0; i < 4000; i++) begin
         int unsigned r = $urandom % 16;
         logic t = ($urandom % 4) == 0;
         logic [4:0] ra = 5'($urandom % 32);
         if (r < 2)
            cyc(1, 5'h04, 32'($urandom % 3000), t);
         else if (r < 4)
            cyc(1, 5'h08, 32'h4755, t);
         else if (r == 4)
            cyc(1, 5'h08, $urandom, t);
         else if (r < 7)
            cyc(1, 5'h0C, (32'($urandom % 3) << 10) | 32'($urandom % 128) | 32'(($urandom % 4) != 0), t);
         else if (r == 7)
            cyc(1, 5'h14, 32'($urandom % 2), t);
         else if (r == 8)
            cyc(1, ra, $urandom, t);
         else
            cyc(0, ra, 0, t);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   logic [4:0] model_rd_addrs [6] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14};
endmodule